// File: doc/BRIEF.md
# Pixel Format Palette Expander

This block sits in a display pipeline between the memory fetch stage and the blending or timing logic. Each cycle it may accept one stored pixel word with a small format code, a 4-bit palette base and a palette-bypass flag. It returns one 8-bit red, green, blue and alpha set per accepted pixel, one clock later, with a valid strobe that travels alongside.

Indexed pixels are looked up in an internal 1024-entry colour table. The host loads that table through a single write port. Direct-colour pixels are split into their packed bit fields. Any 5-bit or 6-bit field is widened to 8 bits by repeating its top bits, so that full scale maps to 0xFF. The bypass flag lets an indexed window skip the table and show its index as a grey level.

Top module: `pxe_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0. Whenever `out_valid` is 0, all four colour outputs are 0.
- R2: Every cycle with `in_valid` high yields exactly one cycle with `out_valid` high, on the next clock, with results kept in input order. `out_valid` is never high without such an input.
- R3: A host write with `pal_idx` below 1024 stores `pal_wdata` in that table entry. Format code 0 (8-bit indexed) outputs the addressed entry, which holds alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0.
- R4: The table address for an indexed pixel is (`in_base` × 64) + `in_pixel[7:0]`, taken modulo 1024.
- R5: A host write with `pal_idx` of 1024 or above is dropped and no table entry changes.
- R6: Format code 1 (5-6-5) takes red from pixel bits 4:0, green from 10:5 and blue from 15:11. Each field is widened by repeating its top bits, and alpha is 0xFF.
- R7: Format code 2 (1-5-5-5) takes red from bits 4:0, green from 9:5 and blue from 14:10, each widened as in R6. Alpha is 0xFF when bit 15 is 1 and 0x00 when it is 0.
- R8: Format code 4 (24-bit) takes red from bits 7:0, green from 15:8 and blue from 23:16. Alpha is 0xFF and bits 31:24 are ignored.
- R9: Format code 5 (32-bit) unpacks as R8 but takes alpha from bits 31:24.
- R10: With `in_bypass` high, format code 0 outputs red, green and blue all equal to `in_pixel[7:0]`, with alpha 0xFF, and does not use the table. For the direct codes, `in_bypass` has no effect.
- R11: Unused format codes 3, 6 and 7 still produce a valid output, and all four channels of that output are 0.
- R12: When a host write and an indexed read hit the same entry in the same cycle, the read returns the contents that entry held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_we | input | 1 | Host table write strobe |
| pal_idx | input | 11 | Host table write index; 1024 and above are rejected |
| pal_wdata | input | 32 | Table entry {alpha, red, green, blue} |
| in_valid | input | 1 | Pixel input valid |
| in_pixel | input | 32 | Stored pixel word, right-aligned |
| in_fmt | input | 3 | Format code |
| in_base | input | 4 | Palette base, in units of 64 entries |
| in_bypass | input | 1 | Skip the table for indexed pixels |
| out_valid | output | 1 | Output valid |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |
| out_a | output | 8 | Alpha |

## Verification
Every colour result, whether it comes from the table or from the field unpacker, is due one clock after its input cycle, together with `out_valid`. Table writes take effect at the edge that samples them, so a read driven on the following cycle sees the new data. A read in the same cycle as the write sees the old data. The driver predicts each result from a shadow copy of the table at the moment it drives the pixel, and queues that prediction. The monitor samples a few nanoseconds after each rising edge and pops one prediction for every `out_valid` it sees, so both a missing result and an extra result show up as mismatches.

// File: rtl/pxe_pkg.sv
// Package: shared format codes and field-widening helpers for the pixel expander.
// Assumes fields are right-aligned and widened by repeating their top bits.
package pxe_pkg;

    typedef enum logic [2:0] {
        FMT_IDX8   = 3'd0,
        FMT_565    = 3'd1,
        FMT_1555   = 3'd2,
        FMT_RSV3   = 3'd3,
        FMT_RGB24  = 3'd4,
        FMT_ARGB32 = 3'd5,
        FMT_RSV6   = 3'd6,
        FMT_RSV7   = 3'd7
    } pxe_fmt_e;

    // Widen a 5-bit field to 8 bits so that 5'h1f maps to 8'hff.
    function automatic logic [7:0] widen5(input logic [4:0] x);
        return {x, x[4:2]};
    endfunction

    // Widen a 6-bit field to 8 bits so that 6'h3f maps to 8'hff.
    function automatic logic [7:0] widen6(input logic [5:0] x);
        return {x, x[5:4]};
    endfunction

endpackage

// File: rtl/pxe_palette.sv
// Module: colour table with one host write port and one synchronous read port.
// Assumes: writes to an index at or above DEPTH are dropped; the read is
// read-first, so a same-cycle write to the read entry shows up one read later.
module pxe_palette #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int HIDX_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              wr_ok;

    // Accept only writes that fall inside the table.
    always_comb wr_ok = wr_en && (wr_idx < HIDX_W'(DEPTH));

    // Store accepted host writes.
    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[wr_idx[IDX_W-1:0]] <= wr_data;
    end

    // Registered read; keeps its value when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem_q[rd_idx];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < HIDX_W'(DEPTH)) |=> mem_q[$past(wr_idx[IDX_W-1:0])] == $past(wr_data)); // R3

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wr_idx < HIDX_W'(DEPTH))) |=>
        mem_q[$past(wr_idx[IDX_W-1:0])] == $past(mem_q[wr_idx[IDX_W-1:0]])); // R5

endmodule

// File: rtl/pxe_unpack.sv
// Module: combinational unpacker for the direct-colour formats.
// Assumes: red is the lowest field, green sits above it, then blue, then alpha.
// Indexed and unused codes return all zeros; the top level handles indexed pixels.
module pxe_unpack
    import pxe_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic [PIX_W-1:0] pixel,
    input  logic [2:0]       fmt,
    output logic [31:0]      argb
);

    // Split the pixel into alpha, red, green and blue for each direct format.
    always_comb begin
        argb = '0;
        case (pxe_fmt_e'(fmt))
            FMT_565:    argb = {8'hff, widen5(pixel[4:0]), widen6(pixel[10:5]), widen5(pixel[15:11])};
            FMT_1555:   argb = {{8{pixel[15]}}, widen5(pixel[4:0]), widen5(pixel[9:5]), widen5(pixel[14:10])};
            FMT_RGB24:  argb = {8'hff, pixel[7:0], pixel[15:8], pixel[23:16]};
            FMT_ARGB32: argb = {pixel[31:24], pixel[7:0], pixel[15:8], pixel[23:16]};
            default:    argb = '0;
        endcase
    end

endmodule

// File: rtl/pxe_top.sv
// Module: pixel format expander top. Turns one stored pixel per cycle into
// 8-bit red, green, blue and alpha one clock later, using either the colour
// table (indexed) or the field unpacker (direct).
// Assumes: in_pixel is right-aligned; the base register counts 64-entry steps.
module pxe_top
    import pxe_pkg::*;
#(
    parameter int PAL_DEPTH  = 1024,
    parameter int PIX_W      = 32,
    parameter int BASE_W     = 4,
    parameter int BASE_SHIFT = 6,
    localparam int IDX_W     = $clog2(PAL_DEPTH),
    localparam int HIDX_W    = IDX_W + 1,
    localparam int SUM_W     = IDX_W + BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_we,
    input  logic [HIDX_W-1:0] pal_idx,
    input  logic [31:0]       pal_wdata,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic [2:0]        in_fmt,
    input  logic [BASE_W-1:0] in_base,
    input  logic              in_bypass,
    output logic              out_valid,
    output logic [7:0]        out_r,
    output logic [7:0]        out_g,
    output logic [7:0]        out_b,
    output logic [7:0]        out_a
);

    logic             is_idx, rd_en;
    logic [SUM_W-1:0] idx_sum;
    logic [IDX_W-1:0] rd_idx;
    logic [31:0]      pal_q, dir_w, dir_q, sel_w;
    logic             v_q, idx_q, byp_q;
    logic [7:0]       grey_q;

    // Work out the table address: base in 64-entry steps plus the index, wrapped.
    always_comb begin
        is_idx  = (pxe_fmt_e'(in_fmt) == FMT_IDX8);
        rd_en   = in_valid && is_idx && !in_bypass;
        idx_sum = (SUM_W'(in_base) << BASE_SHIFT) + SUM_W'(in_pixel[7:0]);
        rd_idx  = idx_sum[IDX_W-1:0];
    end

    pxe_palette #(.DEPTH(PAL_DEPTH), .DATA_W(32)) u_pal (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pal_we),
        .wr_idx  (pal_idx),
        .wr_data (pal_wdata),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (pal_q)
    );

    pxe_unpack #(.PIX_W(PIX_W)) u_unp (
        .pixel (in_pixel),
        .fmt   (in_fmt),
        .argb  (dir_w)
    );

    // Register the direct result and the path selection beside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            idx_q  <= 1'b0;
            byp_q  <= 1'b0;
            grey_q <= '0;
            dir_q  <= '0;
        end else begin
            v_q    <= in_valid;
            idx_q  <= is_idx;
            byp_q  <= in_bypass;
            grey_q <= in_pixel[7:0];
            dir_q  <= dir_w;
        end
    end

    // Pick the output source and force zeros when no pixel is valid.
    always_comb begin
        if (!v_q)       sel_w = '0;
        else if (!idx_q) sel_w = dir_q;
        else if (byp_q)  sel_w = {8'hff, grey_q, grey_q, grey_q};
        else             sel_w = pal_q;
        out_valid = v_q;
        out_a     = sel_w[31:24];
        out_r     = sel_w[23:16];
        out_g     = sel_w[15:8];
        out_b     = sel_w[7:0];
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_r == 8'h00 && out_a == 8'h00)); // R1

    AST_565_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 3'd1 && in_pixel[15:0] == 16'hffff) |=>
        ({out_r, out_g, out_b, out_a} == 32'hffffffff)); // R6

    AST_1555_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 3'd2) |=> (out_a == ($past(in_pixel[15]) ? 8'hff : 8'h00))); // R7

    AST_RGB24_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 3'd4) |=> out_a == 8'hff); // R8

    AST_BYPASS_GREY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt == 3'd0 && in_bypass) |=>
        (out_r == $past(in_pixel[7:0]) && out_g == out_r && out_b == out_r)); // R10

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_fmt == 3'd3 || in_fmt[2:1] == 2'b11)) |=>
        ({out_r, out_g, out_b, out_a} == 32'h0)); // R11

endmodule

// File: tb/sim_pxe_top.sv
module sim_pxe_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_we = 1'b0;
    logic [10:0] pal_idx = '0;
    logic [31:0] pal_wdata = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_pixel = '0;
    logic [2:0]  in_fmt = '0;
    logic [3:0]  in_base = '0;
    logic        in_bypass = 1'b0;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b, out_a;

    int checks = 0;
    int errors = 0;
    logic [31:0] shadow [1024];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    pxe_top u0 (
        .clk(clk), .rst_n(rst_n), .pal_we(pal_we), .pal_idx(pal_idx),
        .pal_wdata(pal_wdata), .in_valid(in_valid), .in_pixel(in_pixel),
        .in_fmt(in_fmt), .in_base(in_base), .in_bypass(in_bypass),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g),
        .out_b(out_b), .out_a(out_a)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] w5(input logic [4:0] x);
        return 8'((x << 3) | (x >> 2));
    endfunction
    function automatic logic [7:0] w6(input logic [5:0] x);
        return 8'((x << 2) | (x >> 4));
    endfunction

    // Expected {a,r,g,b} computed from the requirements and the shadow table.
    function automatic logic [31:0] model(input logic [31:0] p, input logic [2:0] f,
                                          input logic [3:0] base, input logic byp);
        logic [9:0] a;
        case (f)
            3'd0: begin
                a = 10'(({6'd0, base} << 6) + {2'd0, p[7:0]});
                return byp ? {8'hff, p[7:0], p[7:0], p[7:0]} : shadow[a];
            end
            3'd1: return {8'hff, w5(p[4:0]), w6(p[10:5]), w5(p[15:11])};
            3'd2: return {(p[15] ? 8'hff : 8'h00), w5(p[4:0]), w5(p[9:5]), w5(p[14:10])};
            3'd4: return {8'hff, p[7:0], p[15:8], p[23:16]};
            3'd5: return {p[31:24], p[7:0], p[15:8], p[23:16]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; optional write and optional pixel.
    task automatic step(input logic we, input logic [10:0] wi, input logic [31:0] wd,
                        input logic v, input logic [31:0] p, input logic [2:0] f,
                        input logic [3:0] base, input logic byp, input string tag);
        @(negedge clk);
        pal_we = we; pal_idx = wi; pal_wdata = wd;
        in_valid = v; in_pixel = p; in_fmt = f; in_base = base; in_bypass = byp;
        if (v) begin
            exp_q.push_back(model(p, f, base, byp));
            tag_q.push_back(tag);
        end
        if (we && wi < 11'd1024) shadow[wi[9:0]] = wd;
    endtask

    task automatic wr(input logic [10:0] wi, input logic [31:0] wd);
        step(1'b1, wi, wd, 1'b0, '0, '0, '0, 1'b0, "");
    endtask
    task automatic px(input logic [31:0] p, input logic [2:0] f, input logic [3:0] base,
                      input logic byp, input string tag);
        step(1'b0, '0, '0, 1'b1, p, f, base, byp, tag);
    endtask
    task automatic idle();
        step(1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b0, "");
    endtask

    // Monitor: sample after each edge and compare against the queued prediction.
    always begin
        @(posedge clk);
        #3;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected out_valid", 32'h1, 32'h0);
            end else begin
                string t;
                logic [31:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {out_a, out_r, out_g, out_b}, e);
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {7'd0, out_valid, out_a, out_r, out_g}, 32'h0);
        rst_n = 1'b1;
        #3;
        check("R1 after reset", {31'd0, out_valid}, 32'h0);

        wr(11'd3,   32'h80112233);
        wr(11'd5,   32'h11aabbcc);
        wr(11'd71,  32'h44556677);
        wr(11'd191, 32'hdeadbeef);
        wr(11'd1029, 32'hffffffff);   // R5: out of range, dropped
        idle();
        px(32'h00000003, 3'd0, 4'd0,  1'b0, "R3 indexed entry 3");
        px(32'h00000007, 3'd0, 4'd1,  1'b0, "R4 base 1 index 7");
        px(32'h000000ff, 3'd0, 4'd15, 1'b0, "R4 wrap to 191");
        px(32'h00000005, 3'd0, 4'd0,  1'b0, "R5 entry 5 kept");
        px(32'h0000ffff, 3'd1, 4'd0,  1'b0, "R6 565 full scale");
        px(32'h00000000, 3'd1, 4'd0,  1'b0, "R6 565 zero");
        px(32'h00001234, 3'd1, 4'd0,  1'b0, "R6 565 pattern");
        px(32'h0000c21f, 3'd2, 4'd0,  1'b0, "R7 1555 alpha set");
        px(32'h00007fff, 3'd2, 4'd0,  1'b0, "R7 1555 alpha clear");
        px(32'hab123456, 3'd4, 4'd0,  1'b0, "R8 24-bit");
        px(32'hab123456, 3'd5, 4'd0,  1'b0, "R9 32-bit alpha");
        px(32'h0000005a, 3'd0, 4'd3,  1'b1, "R10 bypass grey");
        px(32'h00654321, 3'd4, 4'd0,  1'b1, "R10 bypass ignored on direct");
        px(32'hffffffff, 3'd3, 4'd0,  1'b0, "R11 code 3");
        px(32'hffffffff, 3'd6, 4'd0,  1'b0, "R11 code 6");
        px(32'hffffffff, 3'd7, 4'd0,  1'b0, "R11 code 7");
        idle();
        step(1'b1, 11'd3, 32'h01020304, 1'b1, 32'h3, 3'd0, 4'd0, 1'b0, "R12 read-first");
        px(32'h00000003, 3'd0, 4'd0, 1'b0, "R12 new data next read");
        idle();
        idle();
        idle();
        check("R2 all results seen", 32'(exp_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule